// File: doc/BRIEF.md
# Status Register Write Protection Unit

This unit holds the 8-bit status register of a serial flash memory and decides which writes are allowed. It receives already-decoded command strobes from a serial front end: write-enable, write-disable, a status write carrying the new protection bits, and the end of a chip-select frame. It applies these strobes to the write-enable latch and to the nonvolatile protection field. A status write does not take effect at once. It runs a self-timed cycle whose length is counted in system clocks.

The unit combines the write-protect pin, the protect-enable bit and the block-protect level into two registered verdicts. The first says whether a queried array address is locked. The second says whether the status register is currently hardware protected. When the front end asks for the status byte, the unit returns it. While any internal write is running, whether its own status cycle or an array program or erase reported by the array engine, the byte reads as all ones.

Top module: `sr_prot_unit`

## Requirements
- R1: After synchronous reset, `status_q` is 8'h00, `busy` is 0, `addr_locked` is 0 and `sr_write_inhibit` is 0.
- R2: A write-enable strobe sets the enable latch and a write-disable strobe clears it, whatever the level of `wp_n`, when no internal write is running.
- R3: The status byte is laid out as: bit 7 protect-enable, bits 6..2 the block-protect code (bit 6 most significant), bit 1 the enable latch, bit 0 busy (1 = busy).
- R4: A status write presented while the enable latch is 0 is refused: no cycle starts and the register keeps its value.
- R5: An accepted status write starts its cycle on the `cs_rise` strobe. `busy` then stays high for exactly WRSR_CYCLES clocks. At the end, status bits 7..2 take `wrsr_nv[5:0]` and the enable latch clears.
- R6: While any internal write is running, the status byte reads 8'hFF, and write-enable, write-disable and status-write strobes have no effect.
- R7: The 5-bit block-protect code selects a level. Code 0 locks nothing. Codes 1 to 6 lock, in turn, addresses from 07E000h, 07C000h, 078000h, 070000h, 060000h and 040000h up to the top of a 512 KiB array. Every other code locks the whole array. `chk_addr_hi` carries address bits 18..13.
- R8: Hardware protection is active only when `wp_n` is 0 and the protect-enable bit is 1. In that state status writes are refused, but unlocked addresses stay writable. With the protect-enable bit at 0, `wp_n` low has no effect.
- R9: If hardware protection becomes active after a status write is loaded but before `cs_rise`, the pending write is cancelled. If it becomes active once the cycle has started, the cycle completes normally.
- R10: An `array_done` strobe from the array engine clears the enable latch.
- R11: `sr_write_inhibit` reports the hardware-protection state, one clock after the inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wp_n | input | 1 | Write-protect pin, active low |
| cmd_wren | input | 1 | Write-enable command strobe |
| cmd_wrdi | input | 1 | Write-disable command strobe |
| wrsr_load | input | 1 | Status-write data strobe, sent while the frame is open |
| wrsr_nv | input | 6 | Written byte bits 7..2 (protect-enable, protect code) |
| cs_rise | input | 1 | End-of-frame strobe (chip select released) |
| array_busy | input | 1 | Array program or erase in progress |
| array_done | input | 1 | Array program or erase finished |
| chk_addr_hi | input | 6 | Address bits 18..13 to test against the lock range |
| status_q | output | 8 | Status byte as returned to a status read |
| busy | output | 1 | Any internal write running |
| addr_locked | output | 1 | Queried address is read-only |
| sr_write_inhibit | output | 1 | Status register hardware protected |

## Verification
A wrong protection code or a wrong enable-latch value shows up in `status_q` two clocks after the strobe. A wrong level decode flips `addr_locked` one clock after the query, so the bench sweeps every level at the edge addresses of each range. A miscounted cycle shows as a `busy` pulse of the wrong length. A pending write that is not cancelled, or a strobe that leaks through during busy, leaves the register holding a value it should not have, and this is visible as soon as busy drops.

// File: rtl/sr_prot_pkg.sv
package sr_prot_pkg;
  localparam int SR_W      = 8;
  localparam int BP_W      = 5;
  localparam int NV_W      = BP_W + 1;
  localparam int LOCK_BITS = 6;
  localparam int LVL_W     = 3;
  localparam int LVL_ALL   = 7;

  // map a protect code onto a lock level; out-of-table codes lock all
  function automatic logic [LVL_W-1:0] bp_level(input logic [BP_W-1:0] bp);
    if (bp <= 5'd6) return bp[LVL_W-1:0];
    return LVL_W'(LVL_ALL);
  endfunction
endpackage

// File: rtl/sr_lock_decode.sv
module sr_lock_decode
  import sr_prot_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic [BP_W-1:0]      bp,
  input  logic [LOCK_BITS-1:0] addr_hi,
  output logic                 locked_q
);
  localparam int NLVL = LVL_ALL + 1;

  logic [NLVL-1:0]  top_hit;
  logic [LVL_W-1:0] lvl;

  assign lvl        = bp_level(bp);
  assign top_hit[0] = 1'b0;
  assign top_hit[NLVL-1] = 1'b1;

  // level k locks the top 1/2^(7-k) of the array: top (7-k) bits all ones
  generate
    for (genvar k = 1; k < NLVL - 1; k++) begin : g_lvl
      assign top_hit[k] = &addr_hi[LOCK_BITS-1 -: (LOCK_BITS + 1 - k)];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) locked_q <= 1'b0;
    else     locked_q <= top_hit[lvl];
  end

  assert_level0_unlocked_R7: assert property (@(posedge clk) disable iff (rst)
    (bp == '0) |=> !locked_q);
  assert_full_lock_R7: assert property (@(posedge clk) disable iff (rst)
    (bp > 5'd6) |=> locked_q);
endmodule

// File: rtl/sr_cycle_timer.sv
module sr_cycle_timer #(
  parameter int CYC = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int CW = (CYC > 2) ? $clog2(CYC) : 1;

  logic [CW-1:0] cnt;

  assign done = busy && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= CW'(CYC - 1);
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - 1'b1;
    end
  end

  assert_no_restart_R6: assert property (@(posedge clk) disable iff (rst)
    start |-> !busy);
  assert_count_bounded_R5: assert property (@(posedge clk) disable iff (rst)
    busy |-> (cnt <= CW'(CYC - 1)));
endmodule

// File: rtl/sr_prot_unit.sv
module sr_prot_unit
  import sr_prot_pkg::*;
#(
  parameter int WRSR_CYCLES = 64
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wp_n,
  input  logic                 cmd_wren,
  input  logic                 cmd_wrdi,
  input  logic                 wrsr_load,
  input  logic [NV_W-1:0]      wrsr_nv,
  input  logic                 cs_rise,
  input  logic                 array_busy,
  input  logic                 array_done,
  input  logic [LOCK_BITS-1:0] chk_addr_hi,
  output logic [SR_W-1:0]      status_q,
  output logic                 busy,
  output logic                 addr_locked,
  output logic                 sr_write_inhibit
);
  logic            wen_q, wpen_q, pend_q;
  logic [BP_W-1:0] bp_q;
  logic [NV_W-1:0] pend_nv;
  logic            hw_prot, any_busy, wrsr_busy, wrsr_done, wrsr_start;

  assign hw_prot    = ~wp_n & wpen_q;
  assign any_busy   = wrsr_busy | array_busy;
  assign busy       = any_busy;
  assign wrsr_start = pend_q & cs_rise & wen_q & ~hw_prot & ~any_busy;

  sr_cycle_timer #(.CYC(WRSR_CYCLES)) u_timer (
    .clk   (clk),
    .rst   (rst),
    .start (wrsr_start),
    .busy  (wrsr_busy),
    .done  (wrsr_done)
  );

  sr_lock_decode u_lock (
    .clk      (clk),
    .rst      (rst),
    .bp       (bp_q),
    .addr_hi  (chk_addr_hi),
    .locked_q (addr_locked)
  );

  // enable latch and nonvolatile field
  always_ff @(posedge clk) begin
    if (rst) begin
      wen_q  <= 1'b0;
      wpen_q <= 1'b0;
      bp_q   <= '0;
    end else if (wrsr_done) begin
      wpen_q <= pend_nv[NV_W-1];
      bp_q   <= pend_nv[BP_W-1:0];
      wen_q  <= 1'b0;
    end else if (array_done) begin
      wen_q  <= 1'b0;
    end else if (!any_busy) begin
      if (cmd_wren)      wen_q <= 1'b1;
      else if (cmd_wrdi) wen_q <= 1'b0;
    end
  end

  // pending status write, held from data strobe until frame end
  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q  <= 1'b0;
      pend_nv <= '0;
    end else if (!any_busy && wrsr_load && wen_q && !hw_prot) begin
      pend_q  <= 1'b1;
      pend_nv <= wrsr_nv;
    end else if (cs_rise || hw_prot || !wen_q) begin
      pend_q  <= 1'b0;
    end
  end

  // registered read-back and inhibit
  always_ff @(posedge clk) begin
    if (rst) begin
      status_q         <= '0;
      sr_write_inhibit <= 1'b0;
    end else begin
      status_q         <= any_busy ? {SR_W{1'b1}} : {wpen_q, bp_q, wen_q, 1'b0};
      sr_write_inhibit <= hw_prot;
    end
  end

  assert_busy_reads_ones_R6: assert property (@(posedge clk) disable iff (rst)
    any_busy |=> (status_q == {SR_W{1'b1}}));
  assert_wrsr_needs_wen_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(wrsr_busy) |-> $past(wen_q));
  assert_no_start_under_hw_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(wrsr_busy) |-> !$past(hw_prot));
  assert_wen_cleared_at_end_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(wrsr_busy) |-> !wen_q);
  assert_field_moves_only_at_end_R5: assert property (@(posedge clk) disable iff (rst)
    !$stable(bp_q) |-> $fell(wrsr_busy));
endmodule

// File: tb/test_sr_prot_unit.sv
`timescale 1ns/1ps
module test_sr_prot_unit;
  localparam int NCYC = 12;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wp_n = 1'b1, cmd_wren = 1'b0, cmd_wrdi = 1'b0, wrsr_load = 1'b0;
  logic [5:0] wrsr_nv = '0;
  logic       cs_rise = 1'b0, array_busy = 1'b0, array_done = 1'b0;
  logic [5:0] chk_addr_hi = '0;
  logic [7:0] status_q;
  logic       busy, addr_locked, sr_write_inhibit;

  always #2.5 clk = ~clk;

  sr_prot_unit #(.WRSR_CYCLES(NCYC)) i_sr_prot_unit (
    .clk(clk), .rst(rst), .wp_n(wp_n), .cmd_wren(cmd_wren), .cmd_wrdi(cmd_wrdi),
    .wrsr_load(wrsr_load), .wrsr_nv(wrsr_nv), .cs_rise(cs_rise),
    .array_busy(array_busy), .array_done(array_done), .chk_addr_hi(chk_addr_hi),
    .status_q(status_q), .busy(busy), .addr_locked(addr_locked),
    .sr_write_inhibit(sr_write_inhibit));

  typedef struct {
    int         kind;   // 0 status, 1 busy, 2 locked, 3 inhibit
    logic [7:0] exp;
    string      tag;
  } item_t;

  item_t q[$];
  int    n_chk = 0, n_fail = 0;
  bit    finished = 1'b0;

  // monitor: pops expected items and compares them against the outputs
  initial begin
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        item_t it;
        logic [7:0] act;
        it = q.pop_front();
        case (it.kind)
          0: act = status_q;
          1: act = {7'd0, busy};
          2: act = {7'd0, addr_locked};
          default: act = {7'd0, sr_write_inhibit};
        endcase
        n_chk++;
        if (act !== it.exp) begin
          n_fail++;
          $display("FAIL %s kind=%0d actual=%h expected=%h", it.tag, it.kind, act, it.exp);
        end
      end
    end
  end

  task automatic expect_item(input int kind, input logic [7:0] exp, input string tag);
    item_t it;
    it.kind = kind; it.exp = exp; it.tag = tag;
    q.push_back(it);
    wait (q.size() == 0);
  endtask

  task automatic check_val(input int act, input int exp, input string tag);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk); s = 1'b1;
    @(negedge clk); s = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    settle(2);
  endtask

  task automatic wrsr(input logic [5:0] nv);
    wrsr_nv = nv;
    pulse(wrsr_load);
    pulse(cs_rise);
    wait_idle();
  endtask

  // expected lock from the level table of R7
  function automatic bit exp_lock(input logic [4:0] code, input logic [5:0] hi);
    logic [18:0] a, base;
    a = {hi, 13'd0};
    case (code)
      5'd0: return 1'b0;
      5'd1: base = 19'h7E000;
      5'd2: base = 19'h7C000;
      5'd3: base = 19'h78000;
      5'd4: base = 19'h70000;
      5'd5: base = 19'h60000;
      5'd6: base = 19'h40000;
      default: base = 19'h00000;
    endcase
    return a >= base;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int         cnt;
    logic [4:0] code;
    logic [5:0] probe[4];
    settle(3);
    rst = 1'b0;
    settle(1);
    // R1 reset state
    expect_item(0, 8'h00, "R1 status after reset");
    expect_item(1, 8'h00, "R1 busy after reset");
    expect_item(2, 8'h00, "R1 locked after reset");
    expect_item(3, 8'h00, "R1 inhibit after reset");

    // R2 / R3 enable latch at bit 1
    pulse(cmd_wren); settle(2);
    expect_item(0, 8'h02, "R2 R3 wren sets bit1");
    pulse(cmd_wrdi); settle(2);
    expect_item(0, 8'h00, "R2 wrdi clears");
    wp_n = 1'b0;
    pulse(cmd_wren); pulse(cmd_wrdi); settle(2);
    expect_item(0, 8'h00, "R2 wrdi with wp_n low");
    wp_n = 1'b1;

    // R4 refused without enable
    wrsr(6'b100011);
    expect_item(0, 8'h00, "R4 wrsr without wen");

    // R5 cycle length and loaded bits
    pulse(cmd_wren);
    wrsr_nv = 6'b000011;
    pulse(wrsr_load);
    pulse(cs_rise);
    cnt = 0;
    while (busy) begin cnt++; @(negedge clk); end
    check_val(cnt, NCYC, "R5 busy length");
    settle(2);
    expect_item(0, 8'h0C, "R5 R3 field loaded, wen cleared");

    // R6 status reads all ones during a status cycle
    pulse(cmd_wren);
    wrsr_nv = 6'b000000;
    pulse(wrsr_load);
    pulse(cs_rise);
    expect_item(0, 8'hFF, "R6 ones during status cycle");
    wait_idle();
    expect_item(0, 8'h00, "R5 cleared field");

    // R7 level sweep
    probe[0] = 6'h00; probe[1] = 6'h1F; probe[2] = 6'h3E; probe[3] = 6'h3F;
    for (int c = 0; c < 9; c++) begin
      code = (c == 8) ? 5'h1F : c[4:0];
      pulse(cmd_wren);
      wrsr({1'b0, code});
      for (int p = 0; p < 8; p++) begin
        logic [5:0] hi;
        if (p < 4) hi = probe[p];
        else       hi = 6'(6'h3F << (p - 3));
        chk_addr_hi = hi;
        settle(2);
        expect_item(2, {7'd0, exp_lock(code, hi)}, $sformatf("R7 code %0d hi %h", code, hi));
      end
    end

    // R8 hardware protection
    pulse(cmd_wren);
    wrsr(6'b100000);
    expect_item(0, 8'h80, "R8 wpen set");
    wp_n = 1'b0; settle(2);
    expect_item(3, 8'h01, "R11 inhibit active");
    pulse(cmd_wren);
    wrsr(6'b100111);
    expect_item(0, 8'h82, "R8 wrsr refused under hw protect");
    chk_addr_hi = 6'h00; settle(2);
    expect_item(2, 8'h00, "R8 unlocked stays writable");

    // R9 cancel before frame end, no effect after start
    wp_n = 1'b1;
    wrsr_nv = 6'b100001;
    pulse(wrsr_load);
    @(negedge clk); wp_n = 1'b0;
    pulse(cs_rise); settle(1);
    expect_item(1, 8'h00, "R9 pending cancelled");
    expect_item(0, 8'h82, "R9 register unchanged");
    wp_n = 1'b1;
    pulse(wrsr_load);
    pulse(cs_rise);
    wp_n = 1'b0;
    wait_idle();
    expect_item(0, 8'h84, "R9 started cycle completes");
    expect_item(3, 8'h01, "R11 inhibit with wpen and wp low");

    // R10 array completion clears enable
    wp_n = 1'b1;
    pulse(cmd_wren); settle(2);
    expect_item(0, 8'h86, "R10 wen set");
    pulse(array_done); settle(2);
    expect_item(0, 8'h84, "R10 array_done clears wen");

    // R8 wp_n ignored with wpen clear
    pulse(cmd_wren);
    wrsr(6'b000000);
    wp_n = 1'b0;
    pulse(cmd_wren);
    wrsr(6'b000010);
    expect_item(0, 8'h08, "R8 write accepted with wpen 0");
    expect_item(3, 8'h00, "R11 no inhibit with wpen 0");
    wp_n = 1'b1;

    // R6 array busy: ones, strobes ignored
    pulse(cmd_wren); settle(2);
    expect_item(0, 8'h0A, "R6 wen before array busy");
    @(negedge clk); array_busy = 1'b1;
    settle(2);
    expect_item(0, 8'hFF, "R6 ones during array busy");
    pulse(cmd_wrdi);
    wrsr_nv = 6'b111111;
    pulse(wrsr_load);
    pulse(cs_rise);
    @(negedge clk); array_busy = 1'b0;
    settle(2);
    expect_item(0, 8'h0A, "R6 strobes ignored while busy");

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule